// File: doc/BRIEF.md
# Programmable Parallel Port Register Core

This block sits between a processor bus and twenty-four general-purpose pins arranged as three byte-wide ports (A, B and C). Port C is split into an upper and a lower nibble. The processor reaches the block through a byte-wide data bus, a two-bit register select, and active-low select, read and write strobes. Each port has its own input pins, output values and per-bit output enables. The pad drivers outside the block combine these into tri-state pins.

Writes to the control address carry one of two formats, and bit 7 tells them apart. A configuration word sets the direction of each port and of each port C nibble, and it also carries mode fields. Those mode fields are stored and can be read back, but they do not change how the ports behave. The other format is a command that sets or clears one chosen port C bit. Only plain, unhandshaked transfers are supported.

Top module: `ppi_core`

## Requirements
- R1: Register select 0 is port A, 1 is port B, 2 is port C and 3 is the control register. `dout_oe` is high exactly while `cs_n` and `rd_n` are both low, and `dout` is zero whenever `dout_oe` is low.
- R2: After reset all output enables are zero, all output latches are zero, and a read of the control address returns 0x9B.
- R3: A control write with bit 7 set loads the configuration word. Bit 4 gives the port A direction, bit 3 the port C upper nibble, bit 1 port B and bit 0 the port C lower nibble, with 1 meaning input (enables low) and 0 meaning output (enables high). For example, 0x8A gives `pa_oe`=0xFF, `pb_oe`=0x00 and `pc_oe`=0x0F.
- R4: The mode fields (bits 6:5 for group A, bit 2 for group B) are stored and returned on a control read, and they have no effect on the port outputs or enables.
- R5: A control write with bit 7 clear writes the value in bit 0 into the port C latch bit numbered by bits 3:1, and bits 6:4 are ignored. For example, 0x0B sets bit 5.
- R6: A single-bit command leaves the stored configuration word, the port A and B latches, and all output enables unchanged, and it changes no other port C bit.
- R7: A write to a port address loads that port's output latch whatever its direction, and the latch holds that value until it is written again.
- R8: A read of a port, or of a port C nibble, that is set as input returns the live pin value at the time of the read.
- R9: A read of a port, or of a port C nibble, that is set as output returns its latch value. The two nibbles of port C are chosen independently.
- R10: A write takes effect on the clock edge that first samples `wr_n` high after a low period during which `cs_n` was low. A write strobe while `cs_n` is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low block select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Read data bus enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
Port C gets the most attention, because its two nibbles are read back in opposite directions at the same time. A design that chose one direction for the whole byte would return the wrong upper nibble. The single-bit commands include junk values in bits 6:4. A decoder that used those bits, or that copied the command into the configuration word, would flip the wrong pin or clobber the direction and mode settings. The bench also loads the port B latch while that port is an input and reads it back after switching to output, and it changes pins between reads. These steps catch a design that blocks latch writes on input ports or that holds a stale pin sample. A write strobe with select high is also driven, and any state change it causes shows up as a corrupted latch.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int PORT_W   = 8;
    localparam int NIB_W    = PORT_W / 2;
    localparam int SEL_W    = 2;
    localparam int BIT_IDX_W = $clog2(PORT_W);
    localparam logic [PORT_W-1:0] CFG_RESET = 8'h9B;

    typedef enum logic [SEL_W-1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } ppi_sel_e;

    // configuration word layout, MSB first
    typedef struct packed {
        logic       is_cfg;
        logic [1:0] grp_a_mode;
        logic       a_is_in;
        logic       chi_is_in;
        logic       grp_b_mode;
        logic       b_is_in;
        logic       clo_is_in;
    } cfg_word_t;

    // single-bit command layout, MSB first
    typedef struct packed {
        logic                 is_cfg;
        logic [2:0]           dont_care;
        logic [BIT_IDX_W-1:0] idx;
        logic                 val;
    } bit_cmd_t;

    typedef struct packed {
        logic                 stb;
        ppi_sel_e             sel;
        logic [PORT_W-1:0]    data;
    } host_wr_t;

    function automatic logic [PORT_W-1:0] pick_rd(
        input logic              is_in,
        input logic [PORT_W-1:0] pins,
        input logic [PORT_W-1:0] latch
    );
        return is_in ? pins : latch;
    endfunction

    function automatic logic [PORT_W-1:0] oe_mask(input logic is_in);
        return is_in ? '0 : '1;
    endfunction

endpackage

// File: rtl/ppi_host_if.sv
module ppi_host_if
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [SEL_W-1:0]  addr,
    input  logic [PORT_W-1:0] din,
    output host_wr_t          wr,
    output logic              rd_en
);

    logic              wr_n_q;
    logic              pend_q;
    ppi_sel_e          sel_q;
    logic [PORT_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            pend_q <= 1'b0;
            sel_q  <= SEL_PA;
            data_q <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!cs_n && !wr_n) begin
                pend_q <= 1'b1;
                sel_q  <= ppi_sel_e'(addr);
                data_q <= din;
            end else if (wr_n) begin
                pend_q <= 1'b0;
            end
        end
    end

    // commit on the trailing edge of the strobe
    always_comb begin
        wr.stb  = pend_q && wr_n && !wr_n_q;
        wr.sel  = sel_q;
        wr.data = data_q;
    end

    assign rd_en = !cs_n && !rd_n;

endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
    import ppi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  host_wr_t             wr,
    output cfg_word_t            cfg,
    output logic                 bit_stb,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 bit_val
);

    cfg_word_t cfg_q;
    bit_cmd_t  cmd;
    logic      ctrl_hit;

    assign ctrl_hit = wr.stb && (wr.sel == SEL_CTRL);
    assign cmd      = bit_cmd_t'(wr.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_word_t'(CFG_RESET);
        end else if (ctrl_hit && wr.data[PORT_W-1]) begin
            cfg_q <= cfg_word_t'(wr.data);
        end
    end

    logic unused_dc;
    assign unused_dc = ^cmd.dont_care ^ cmd.is_cfg;

    assign cfg     = cfg_q;
    assign bit_stb = ctrl_hit && !wr.data[PORT_W-1];
    assign bit_idx = cmd.idx;
    assign bit_val = cmd.val;

endmodule

// File: rtl/ppi_out_latch.sv
module ppi_out_latch
    import ppi_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter bit BIT_OP = 1'b0,
    localparam int IW    = $clog2(W)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    input  logic          bit_stb,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);

    logic [W-1:0] nxt;

    generate
        if (BIT_OP) begin : g_bitop
            always_comb begin
                nxt = q;
                if (ld) begin
                    nxt = ld_val;
                end else if (bit_stb) begin
                    nxt[bit_idx] = bit_val;
                end
            end
        end else begin : g_plain
            logic unused_bit;
            assign unused_bit = bit_stb ^ (^bit_idx) ^ bit_val;
            assign nxt = ld ? ld_val : q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/ppi_core.sv
module ppi_core
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [SEL_W-1:0]  addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_oe,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);

    host_wr_t             wr;
    logic                 rd_en;
    cfg_word_t            cfg;
    logic                 bit_stb;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 bit_val;

    ppi_host_if u_host (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .din   (din),
        .wr    (wr),
        .rd_en (rd_en)
    );

    ppi_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .cfg     (cfg),
        .bit_stb (bit_stb),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    localparam int NPORT = 3;
    logic [NPORT-1:0][PORT_W-1:0] latch;
    logic [NPORT-1:0]             ld;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign ld[p] = wr.stb && (wr.sel == ppi_sel_e'(p));
            ppi_out_latch #(
                .W      (PORT_W),
                .BIT_OP (p == int'(SEL_PC))
            ) u_latch (
                .clk     (clk),
                .rst     (rst),
                .ld      (ld[p]),
                .ld_val  (wr.data),
                .bit_stb (bit_stb),
                .bit_idx (bit_idx),
                .bit_val (bit_val),
                .q       (latch[p])
            );
        end
    endgenerate

    assign pa_out = latch[SEL_PA];
    assign pb_out = latch[SEL_PB];
    assign pc_out = latch[SEL_PC];

    assign pa_oe = oe_mask(cfg.a_is_in);
    assign pb_oe = oe_mask(cfg.b_is_in);
    assign pc_oe = {oe_mask(cfg.chi_is_in)[NIB_W-1:0], oe_mask(cfg.clo_is_in)[NIB_W-1:0]};

    logic [PORT_W-1:0] pc_rd;
    logic [PORT_W-1:0] rd_mux;

    always_comb begin
        pc_rd[PORT_W-1:NIB_W] = cfg.chi_is_in ? pc_in[PORT_W-1:NIB_W] : pc_out[PORT_W-1:NIB_W];
        pc_rd[NIB_W-1:0]      = cfg.clo_is_in ? pc_in[NIB_W-1:0]      : pc_out[NIB_W-1:0];
        unique case (ppi_sel_e'(addr))
            SEL_PA:   rd_mux = pick_rd(cfg.a_is_in, pa_in, pa_out);
            SEL_PB:   rd_mux = pick_rd(cfg.b_is_in, pb_in, pb_out);
            SEL_PC:   rd_mux = pc_rd;
            default:  rd_mux = cfg;
        endcase
    end

    assign dout    = rd_en ? rd_mux : '0;
    assign dout_oe = rd_en;

endmodule

// File: rtl/ppi_core_checks.sv
module ppi_core_checks
    import ppi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [SEL_W-1:0]  addr,
    input logic [PORT_W-1:0] din,
    input logic [PORT_W-1:0] dout,
    input logic              dout_oe,
    input logic [PORT_W-1:0] pa_in,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic [PORT_W-1:0] pb_in,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pb_oe,
    input logic [PORT_W-1:0] pc_in,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pc_oe
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R2: one cycle after reset everything is input and zero
    always @(posedge clk) begin
        if (rst_d) begin
            a_r2_reset_idle: assert (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                                     pa_out == '0 && pb_out == '0 && pc_out == '0);
        end
    end

    // R1
    a_r1_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0);

    // R10
    a_r10_no_commit_no_change: assert property (@(posedge clk) disable iff (rst)
        (!wr_n || $past(wr_n)) |=>
            ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
             $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R6
    a_r6_bitcmd_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !$past(wr_n) && !$past(cs_n) && $past(addr) == 2'd3 && !$past(din[7])) |=>
            ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
             $stable(pa_out) && $stable(pb_out)));

    // R5
    a_r5_bitcmd_one_bit: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !$past(wr_n) && !$past(cs_n) && $past(addr) == 2'd3 && !$past(din[7])) |=>
            ($countones(pc_out ^ $past(pc_out)) <= 1));

endmodule

bind ppi_core ppi_core_checks u_chk (.*);

// File: tb/ppi_core_test.sv
module ppi_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    always #2 clk = ~clk;

    ppi_core uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    typedef enum int { O_DOUT, O_DOE, O_PA, O_PAOE, O_PB, O_PBOE, O_PC, O_PCOE } obs_e;
    typedef struct { obs_e sel; logic [7:0] exp; string req; } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic [7:0] observe(obs_e s);
        case (s)
            O_DOUT: return dout;
            O_DOE:  return {7'd0, dout_oe};
            O_PA:   return pa_out;
            O_PAOE: return pa_oe;
            O_PB:   return pb_out;
            O_PBOE: return pb_oe;
            O_PC:   return pc_out;
            default: return pc_oe;
        endcase
    endfunction

    // monitor: compares queued expectations just after the driving negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = observe(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: %s actual %h expected %h", it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(obs_e s, logic [7:0] e, string r);
        item_t it;
        it.sel = s; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d, logic sel_n);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic bus_read(logic [1:0] a, logic [7:0] e, string r);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        expect_out(O_DOUT, e, r);
        expect_out(O_DOE, 8'h01, r);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R2 reset state
        expect_out(O_PAOE, 8'h00, "R2");
        expect_out(O_PBOE, 8'h00, "R2");
        expect_out(O_PCOE, 8'h00, "R2");
        expect_out(O_PA, 8'h00, "R2");
        expect_out(O_PC, 8'h00, "R2");
        expect_out(O_DOE, 8'h00, "R1");
        expect_out(O_DOUT, 8'h00, "R1");
        bus_read(2'd3, 8'h9B, "R2");

        // R3 configuration 0x8A
        bus_write(2'd3, 8'h8A, 1'b0);
        expect_out(O_PAOE, 8'hFF, "R3");
        expect_out(O_PBOE, 8'h00, "R3");
        expect_out(O_PCOE, 8'h0F, "R3");
        bus_read(2'd3, 8'h8A, "R4");

        // R7 / R9 port A output
        bus_write(2'd0, 8'h5A, 1'b0);
        expect_out(O_PA, 8'h5A, "R7");
        pa_in = 8'hC3;
        bus_read(2'd0, 8'h5A, "R9");

        // R8 port B input, live pins
        pb_in = 8'h3C;
        bus_read(2'd1, 8'h3C, "R8");
        pb_in = 8'hC3;
        bus_read(2'd1, 8'hC3, "R8");

        // R7 latch write to an input port
        bus_write(2'd1, 8'h11, 1'b0);
        expect_out(O_PB, 8'h11, "R7");
        expect_out(O_PBOE, 8'h00, "R7");

        // port C mixed nibbles
        bus_write(2'd2, 8'h96, 1'b0);
        expect_out(O_PC, 8'h96, "R7");
        pc_in = 8'h7E;
        bus_read(2'd2, 8'h76, "R9");

        // R5 single-bit commands
        bus_write(2'd3, 8'h0B, 1'b0);
        expect_out(O_PC, 8'hB6, "R5");
        bus_write(2'd3, 8'h77, 1'b0);
        expect_out(O_PC, 8'hBE, "R5");
        bus_write(2'd3, 8'h0E, 1'b0);
        expect_out(O_PC, 8'h3E, "R5");
        // R6 nothing else moved
        expect_out(O_PA, 8'h5A, "R6");
        expect_out(O_PAOE, 8'hFF, "R6");
        expect_out(O_PCOE, 8'h0F, "R6");
        bus_read(2'd3, 8'h8A, "R6");

        // R10 write strobe with select high
        bus_write(2'd0, 8'hEE, 1'b1);
        expect_out(O_PA, 8'h5A, "R10");
        bus_write(2'd3, 8'h80, 1'b1);
        expect_out(O_PAOE, 8'hFF, "R10");
        expect_out(O_PBOE, 8'h00, "R10");

        // R1 read strobe without select
        step();
        rd_n = 1'b0; addr = 2'd0;
        expect_out(O_DOE, 8'h00, "R1");
        expect_out(O_DOUT, 8'h00, "R1");
        step();
        rd_n = 1'b1;

        // R4 mode fields stored, directions all output
        bus_write(2'd3, 8'hE4, 1'b0);
        expect_out(O_PAOE, 8'hFF, "R4");
        expect_out(O_PBOE, 8'hFF, "R4");
        expect_out(O_PCOE, 8'hFF, "R4");
        expect_out(O_PB, 8'h11, "R4");
        bus_read(2'd3, 8'hE4, "R4");
        bus_read(2'd1, 8'h11, "R9");
        bus_read(2'd2, 8'h3E, "R9");

        // all inputs again: port C read from pins
        bus_write(2'd3, 8'h9B, 1'b0);
        expect_out(O_PCOE, 8'h00, "R3");
        pc_in = 8'hA5;
        bus_read(2'd2, 8'hA5, "R8");

        repeat (3) step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule